// File: doc/BRIEF.md
# One-Wire Reset and Presence Detector

This block runs the reset and presence-detect cycle of a one-wire bus master. On a start strobe it holds the line low for a reset interval. It then lets the line go and samples it at two instants. The earlier sample finds a short. The later sample finds a slave's presence pulse. The outcome is reported on two result bits, and a one-clock done pulse marks the moment they change.

At standard speed the master can also drive a brief masking pulldown after release. The pulldown covers the falling edge that a slave makes when it starts its presence pulse, so that sharp edge does not travel down a long network. This mask is never applied at overdrive speed. Every interval is a count of clock cycles and has a separate standard and overdrive value. The speed and mask choices are captured when the cycle starts and hold until it ends.

The line input is taken to be already synchronous to `clk`. Edge slew shaping belongs to the pad and is not part of this block.

Top module: `owr_presence_top`

## Requirements
- R1: After reset, pull_low_o, busy_o, done_o, presence_o and short_o are all 0.
- R2: A start_i seen high on an edge while idle makes pull_low_o 1 for exactly LOW_LEN cycles, beginning with the cycle after that edge. LOW_LEN is the standard or overdrive value, chosen by overdrive_i (1 = overdrive) as sampled on that edge. pull_low_o is never 1 while idle.
- R3: busy_o is 1 for exactly LOW_LEN + REL_LEN cycles after the accepting edge and is 0 otherwise.
- R4: At standard speed with mask_en_i = 1 at start, pull_low_o is 1 again for release offsets MASK_ON up to (but not including) MASK_OFF. The release offset counts from 0 in the first cycle after the reset-low interval.
- R5: At overdrive speed no masking pulldown occurs, whatever mask_en_i is.
- R6: short_o becomes 1 if the line is low in the cycle at release offset SHORT_AT, and 0 otherwise.
- R7: presence_o becomes 1 if the line is low at release offset PRES_AT and no short was seen. presence_o is 0 whenever short_o is 1.
- R8: done_o is a single-cycle pulse in the first cycle after busy_o falls. presence_o and short_o change only in that same cycle and hold their values at all other times, including while idle with the line moving.
- R9: A start_i pulse while busy_o is 1 is ignored. The cycle keeps its length, its pulldown pattern and its results.
- R10: Each new cycle replaces both results, so a cycle with no slave and no short clears bits left at 1 by a previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for a reset/presence cycle |
| overdrive_i | input | 1 | Speed select at start: 1 = overdrive, 0 = standard |
| mask_en_i | input | 1 | Presence-edge masking enable at start |
| line_i | input | 1 | Synchronous sample of the bus line (1 = high) |
| pull_low_o | output | 1 | 1 = drive the bus line low |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-clock completion pulse |
| presence_o | output | 1 | 1 = presence detected by the last cycle |
| short_o | output | 1 | 1 = short detected by the last cycle |

## Verification
Counting from the edge that accepts start_i, the pulldown is due one cycle later and lasts LOW_LEN cycles. The mask window follows at release offsets MASK_ON to MASK_OFF. busy_o is due for LOW_LEN + REL_LEN cycles, and done_o and both results appear together in the cycle that follows. The bench counts edges from the accepting edge. It drives the slave model by release offset, compares every output at the falling clock edge of each cycle, and checks done_o and the results only in their single due cycle. Random speed, mask, slave behaviour and stray start pulses are mixed with directed cases where the line is low exactly at, or just past, each sample instant.

// File: rtl/owr_pkg.sv
package owr_pkg;
    localparam int CNT_W = 16;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_REL  = 2'd2
    } phase_e;

    // One speed's set of intervals, all in clock cycles.
    // Offsets other than low_len are counted from the start of release.
    typedef struct packed {
        cnt_t low_len;
        cnt_t short_at;
        cnt_t mask_on;
        cnt_t mask_off;
        cnt_t pres_at;
        cnt_t rel_len;
    } win_t;
endpackage

// File: rtl/owr_timing_sel.sv
module owr_timing_sel
    import owr_pkg::*;
#(
    parameter int STD_LOW_LEN  = 48,
    parameter int STD_SHORT_AT = 6,
    parameter int STD_MASK_ON  = 10,
    parameter int STD_MASK_OFF = 16,
    parameter int STD_PRES_AT  = 24,
    parameter int STD_REL_LEN  = 40,
    parameter int OD_LOW_LEN   = 12,
    parameter int OD_SHORT_AT  = 2,
    parameter int OD_MASK_ON   = 3,
    parameter int OD_MASK_OFF  = 5,
    parameter int OD_PRES_AT   = 6,
    parameter int OD_REL_LEN   = 12
) (
    input  logic od_i,
    output win_t win_o
);
    localparam win_t STD_WIN = '{
        low_len:  cnt_t'(STD_LOW_LEN),
        short_at: cnt_t'(STD_SHORT_AT),
        mask_on:  cnt_t'(STD_MASK_ON),
        mask_off: cnt_t'(STD_MASK_OFF),
        pres_at:  cnt_t'(STD_PRES_AT),
        rel_len:  cnt_t'(STD_REL_LEN)
    };
    localparam win_t OD_WIN = '{
        low_len:  cnt_t'(OD_LOW_LEN),
        short_at: cnt_t'(OD_SHORT_AT),
        mask_on:  cnt_t'(OD_MASK_ON),
        mask_off: cnt_t'(OD_MASK_OFF),
        pres_at:  cnt_t'(OD_PRES_AT),
        rel_len:  cnt_t'(OD_REL_LEN)
    };

    always_comb begin
        win_o = od_i ? OD_WIN : STD_WIN;
    end
endmodule

// File: rtl/owr_phase_ctrl.sv
module owr_phase_ctrl
    import owr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start_i,
    input  logic   od_i,
    input  logic   mask_en_i,
    input  cnt_t   low_len_i,
    input  cnt_t   mask_on_i,
    input  cnt_t   mask_off_i,
    input  cnt_t   rel_len_i,
    output phase_e phase_o,
    output cnt_t   cnt_o,
    output logic   od_o,
    output logic   finish_o,
    output logic   pull_low_o
);
    typedef struct packed {
        phase_e ph;
        cnt_t   cnt;
        logic   od;
        logic   mask;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic fin_d;

    always_comb begin
        ctl_d = ctl_q;
        fin_d = 1'b0;
        case (ctl_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    ctl_d.ph   = PH_LOW;
                    ctl_d.cnt  = '0;
                    ctl_d.od   = od_i;
                    // masking only ever applies at standard speed
                    ctl_d.mask = mask_en_i & ~od_i;
                end
            end
            PH_LOW: begin
                if (ctl_q.cnt == cnt_t'(low_len_i - cnt_t'(1))) begin
                    ctl_d.ph  = PH_REL;
                    ctl_d.cnt = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + cnt_t'(1);
                end
            end
            PH_REL: begin
                if (ctl_q.cnt == cnt_t'(rel_len_i - cnt_t'(1))) begin
                    ctl_d.ph  = PH_IDLE;
                    ctl_d.cnt = '0;
                    fin_d     = 1'b1;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + cnt_t'(1);
                end
            end
            default: begin
                ctl_d.ph  = PH_IDLE;
                ctl_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{ph: PH_IDLE, cnt: '0, od: 1'b0, mask: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign phase_o    = ctl_q.ph;
    assign cnt_o      = ctl_q.cnt;
    assign od_o       = ctl_q.od;
    assign finish_o   = fin_d;
    assign pull_low_o = (ctl_q.ph == PH_LOW) ||
                        ((ctl_q.ph == PH_REL) && ctl_q.mask &&
                         (ctl_q.cnt >= mask_on_i) && (ctl_q.cnt < mask_off_i));
endmodule

// File: rtl/owr_result.sv
module owr_result
    import owr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_e phase_i,
    input  cnt_t   cnt_i,
    input  cnt_t   short_at_i,
    input  cnt_t   pres_at_i,
    input  logic   line_i,
    input  logic   finish_i,
    output logic   presence_o,
    output logic   short_o,
    output logic   done_o
);
    typedef struct packed {
        logic short_seen;
        logic pres_seen;
        logic short_r;
        logic pres_r;
        logic done;
    } res_t;

    res_t res_d, res_q;

    always_comb begin
        res_d      = res_q;
        res_d.done = finish_i;
        if (phase_i == PH_LOW) begin
            res_d.short_seen = 1'b0;
            res_d.pres_seen  = 1'b0;
        end
        if ((phase_i == PH_REL) && (cnt_i == short_at_i)) begin
            res_d.short_seen = ~line_i;
        end
        if ((phase_i == PH_REL) && (cnt_i == pres_at_i)) begin
            res_d.pres_seen = ~line_i;
        end
        if (finish_i) begin
            res_d.short_r = res_q.short_seen;
            res_d.pres_r  = res_q.pres_seen & ~res_q.short_seen;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign presence_o = res_q.pres_r;
    assign short_o    = res_q.short_r;
    assign done_o     = res_q.done;
endmodule

// File: rtl/owr_presence_top.sv
module owr_presence_top
    import owr_pkg::*;
#(
    parameter int STD_LOW_LEN  = 48,
    parameter int STD_SHORT_AT = 6,
    parameter int STD_MASK_ON  = 10,
    parameter int STD_MASK_OFF = 16,
    parameter int STD_PRES_AT  = 24,
    parameter int STD_REL_LEN  = 40,
    parameter int OD_LOW_LEN   = 12,
    parameter int OD_SHORT_AT  = 2,
    parameter int OD_MASK_ON   = 3,
    parameter int OD_MASK_OFF  = 5,
    parameter int OD_PRES_AT   = 6,
    parameter int OD_REL_LEN   = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic overdrive_i,
    input  logic mask_en_i,
    input  logic line_i,
    output logic pull_low_o,
    output logic busy_o,
    output logic done_o,
    output logic presence_o,
    output logic short_o
);
    phase_e phase;
    cnt_t   cnt;
    logic   od_q;
    logic   finish;
    win_t   win;

    owr_timing_sel #(
        .STD_LOW_LEN (STD_LOW_LEN),  .STD_SHORT_AT(STD_SHORT_AT),
        .STD_MASK_ON (STD_MASK_ON),  .STD_MASK_OFF(STD_MASK_OFF),
        .STD_PRES_AT (STD_PRES_AT),  .STD_REL_LEN (STD_REL_LEN),
        .OD_LOW_LEN  (OD_LOW_LEN),   .OD_SHORT_AT (OD_SHORT_AT),
        .OD_MASK_ON  (OD_MASK_ON),   .OD_MASK_OFF (OD_MASK_OFF),
        .OD_PRES_AT  (OD_PRES_AT),   .OD_REL_LEN  (OD_REL_LEN)
    ) u_sel (
        .od_i  (od_q),
        .win_o (win)
    );

    owr_phase_ctrl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .od_i       (overdrive_i),
        .mask_en_i  (mask_en_i),
        .low_len_i  (win.low_len),
        .mask_on_i  (win.mask_on),
        .mask_off_i (win.mask_off),
        .rel_len_i  (win.rel_len),
        .phase_o    (phase),
        .cnt_o      (cnt),
        .od_o       (od_q),
        .finish_o   (finish),
        .pull_low_o (pull_low_o)
    );

    owr_result u_res (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_i    (phase),
        .cnt_i      (cnt),
        .short_at_i (win.short_at),
        .pres_at_i  (win.pres_at),
        .line_i     (line_i),
        .finish_i   (finish),
        .presence_o (presence_o),
        .short_o    (short_o),
        .done_o     (done_o)
    );

    assign busy_o = (phase != PH_IDLE);
endmodule

// File: rtl/owr_presence_chk.sv
module owr_presence_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic pull_low_o,
    input logic busy_o,
    input logic done_o,
    input logic presence_o,
    input logic short_o
);
    AST_SHORT_BLOCKS_PRES: assert property (@(posedge clk) disable iff (!rst_n)
        short_o |-> !presence_o); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o))); // R3

    AST_RESULTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(presence_o) && $stable(short_o))); // R8

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !pull_low_o); // R2

    AST_START_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && pull_low_o)); // R2
endmodule

bind owr_presence_top owr_presence_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .pull_low_o (pull_low_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .presence_o (presence_o),
    .short_o    (short_o)
);

// File: tb/sim_owr_presence_top.sv
module sim_owr_presence_top;
    localparam int S_LOW = 48, S_SI = 6, S_MON = 10, S_MOFF = 16, S_PRES = 24, S_REL = 40;
    localparam int O_LOW = 12, O_SI = 2, O_MON = 3,  O_MOFF = 5,  O_PRES = 6,  O_REL = 12;

    // slave behaviours
    localparam int SC_NONE = 0, SC_SLAVE = 1, SC_SHORT = 2, SC_GLITCH = 3,
                   SC_LATE = 4, SC_EXACT = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, overdrive_i = 1'b0, mask_en_i = 1'b0;
    logic slave_low = 1'b0;
    logic line_i;
    logic pull_low_o, busy_o, done_o, presence_o, short_o;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    assign line_i = ~(pull_low_o | slave_low);

    owr_presence_top #(
        .STD_LOW_LEN(S_LOW), .STD_SHORT_AT(S_SI), .STD_MASK_ON(S_MON),
        .STD_MASK_OFF(S_MOFF), .STD_PRES_AT(S_PRES), .STD_REL_LEN(S_REL),
        .OD_LOW_LEN(O_LOW), .OD_SHORT_AT(O_SI), .OD_MASK_ON(O_MON),
        .OD_MASK_OFF(O_MOFF), .OD_PRES_AT(O_PRES), .OD_REL_LEN(O_REL)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .overdrive_i(overdrive_i),
        .mask_en_i(mask_en_i), .line_i(line_i), .pull_low_o(pull_low_o),
        .busy_o(busy_o), .done_o(done_o), .presence_o(presence_o), .short_o(short_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    function automatic int low_len(input bit od);  return od ? O_LOW : S_LOW;  endfunction
    function automatic int rel_len(input bit od);  return od ? O_REL : S_REL;  endfunction

    // expected pulldown in cycle k after the accepting edge
    function automatic bit exp_pull(input int k, input bit od, input bit msk);
        int p = k - low_len(od);
        if (k < low_len(od)) return 1'b1;
        if (!msk || od) return 1'b0;
        return (p >= S_MON) && (p < S_MOFF);
    endfunction

    // slave model, by release offset p
    function automatic bit slave_f(input int sc, input int p, input bit od);
        int si = od ? O_SI : S_SI;
        int pr = od ? O_PRES : S_PRES;
        case (sc)
            SC_SLAVE:  return (p >= si + 1) && (p < pr + 3);
            SC_SHORT:  return 1'b1;
            SC_GLITCH: return (p == si);
            SC_LATE:   return (p == pr + 1);
            SC_EXACT:  return (p == pr);
            default:   return 1'b0;
        endcase
    endfunction

    function automatic bit exp_short(input int sc);
        return (sc == SC_SHORT) || (sc == SC_GLITCH);
    endfunction
    function automatic bit exp_pres(input int sc);
        return (sc == SC_SLAVE) || (sc == SC_EXACT);
    endfunction

    task automatic run_one(input bit od, input bit msk, input int sc, input int inj);
        bit pp = presence_o;
        bit ps = short_o;
        int total = low_len(od) + rel_len(od);
        @(negedge clk);
        start_i = 1'b1; overdrive_i = od; mask_en_i = msk;
        @(posedge clk);
        for (int k = 0; k < total; k++) begin
            @(negedge clk);
            start_i     = (k == inj);
            overdrive_i = 1'($urandom);
            mask_en_i   = 1'($urandom);
            slave_low   = (k >= low_len(od)) ? slave_f(sc, k - low_len(od), od) : 1'b0;
            chk(pull_low_o == exp_pull(k, od, msk),
                (k < low_len(od)) ? "R2 reset-low" : (od ? "R5 no mask" : "R4 mask window"),
                pull_low_o, exp_pull(k, od, msk));
            chk(busy_o == 1'b1, "R3 busy", busy_o, 1);
            chk(done_o == 1'b0, "R8 no early done", done_o, 0);
            chk(presence_o == pp && short_o == ps, "R8 results held in cycle",
                {presence_o, short_o}, {pp, ps});
        end
        @(negedge clk);
        start_i = 1'b0; slave_low = 1'b0;
        chk(busy_o == 1'b0, "R3 busy end (R9 if injected)", busy_o, 0);
        chk(done_o == 1'b1, "R8 done", done_o, 1);
        chk(short_o == exp_short(sc), "R6 short", short_o, exp_short(sc));
        chk(presence_o == exp_pres(sc), "R7 presence", presence_o, exp_pres(sc));
        @(negedge clk);
        chk(done_o == 1'b0, "R8 done one cycle", done_o, 0);
    endtask

    task automatic idle_gap(input int n);
        bit pp = presence_o;
        bit ps = short_o;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            slave_low = 1'($urandom);
            chk(!busy_o && !pull_low_o && !done_o, "R2 idle quiet",
                {busy_o, pull_low_o, done_o}, 0);
            chk(presence_o == pp && short_o == ps, "R8 results held idle",
                {presence_o, short_o}, {pp, ps});
        end
        @(negedge clk);
        slave_low = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h1A2B3C));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({pull_low_o, busy_o, done_o, presence_o, short_o} == 5'b0, "R1 reset state",
            {pull_low_o, busy_o, done_o, presence_o, short_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({pull_low_o, busy_o, done_o, presence_o, short_o} == 5'b0, "R1 after release",
            {pull_low_o, busy_o, done_o, presence_o, short_o}, 0);

        // directed corners
        run_one(1'b0, 1'b0, SC_SLAVE,  -1); idle_gap(4);
        run_one(1'b0, 1'b0, SC_NONE,   -1); idle_gap(4);   // R10 clears presence
        run_one(1'b0, 1'b1, SC_SLAVE,  -1); idle_gap(4);   // R4 mask
        run_one(1'b1, 1'b1, SC_SLAVE,  -1); idle_gap(4);   // R5 overdrive ignores mask
        run_one(1'b0, 1'b0, SC_GLITCH, -1); idle_gap(4);   // R6 low only at short instant
        run_one(1'b0, 1'b1, SC_SHORT,  -1); idle_gap(4);   // R7 short wins
        run_one(1'b0, 1'b0, SC_NONE,   -1); idle_gap(4);   // R10 clears short
        run_one(1'b0, 1'b0, SC_EXACT,  -1); idle_gap(4);   // R7 exact instant
        run_one(1'b0, 1'b0, SC_LATE,   -1); idle_gap(4);   // R7 one past
        run_one(1'b1, 1'b0, SC_EXACT,  -1); idle_gap(4);
        run_one(1'b1, 1'b0, SC_GLITCH,  3); idle_gap(4);   // R9 start while busy
        run_one(1'b0, 1'b1, SC_SLAVE,  60); idle_gap(2);   // R9 start in release phase

        // random mix
        for (int r = 0; r < 50; r++) begin
            bit od  = 1'($urandom);
            bit msk = 1'($urandom);
            int sc  = int'($urandom % 6);
            int inj = ($urandom % 3 == 0) ? int'($urandom % (low_len(od) + rel_len(od))) : -1;
            run_one(od, msk, sc, inj);
            idle_gap(int'($urandom % 5));
        end

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule